// File: doc/BRIEF.md
# Reference clock loss monitor

This block checks that a reference oscillator is still producing edges. It uses a separate clock that is assumed never to stop. Each rising edge of the oscillator flips a one-bit marker in the oscillator domain. A chain of flops carries that marker into the monitoring domain, where a change in its level counts as proof of life. A counter in the monitoring domain measures how long it has been since the last sign of life. When the count reaches a parameterised limit, the block declares the oscillator lost.

A failure produces a one-cycle event pulse. It also sets one of two sticky requests, chosen by a configuration input sampled at the moment of failure:
- a request to fall back to self-clocking, or
- a request for a system reset.

Either request stays high until the next global reset. Clearing the monitoring enable switches detection off completely. Acting on the requests, meaning the clock switching and the reset generation, belongs to neighbouring logic.

Top module: `clk_loss_mon`

## Requirements
- R1: During and directly after reset, `fail_evt_o`, `self_clk_req_o` and `sys_rst_req_o` are all low.
- R2: While enabled and while oscillator rising edges arrive at gaps of at most LIMIT-SYNC_STAGES-2 monitoring cycles, `fail_evt_o` stays low and no request is set.
- R3: While enabled, if the oscillator stops, `fail_evt_o` pulses once. The pulse comes at a monitoring rising edge between LIMIT and LIMIT+SYNC_STAGES+2 edges after the later of two events: the last oscillator rising edge, or the cycle in which the enable was raised.
- R4: `fail_evt_o` is high for exactly one cycle. It does not pulse again while the oscillator stays stopped.
- R5: If `self_clk_sel_i` is 1 in the cycle of the failure pulse, `self_clk_req_o` rises in the next cycle and `sys_rst_req_o` stays low.
- R6: If `self_clk_sel_i` is 0 in the cycle of the failure pulse, `sys_rst_req_o` rises in the next cycle and `self_clk_req_o` stays low.
- R7: A request that has been set stays high even if the oscillator resumes. Only reset clears it.
- R8: While `mon_en_i` is 0, no failure pulse and no request is ever produced, even with the oscillator stopped.
- R9: Dropping `mon_en_i` discards the elapsed time. After it is raised again, a full timeout (R3) is needed before a failure.
- R10: A running oscillator whose rising edges are more than LIMIT+SYNC_STAGES+2 monitoring cycles apart is reported as failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk_i | input | 1 | Always-running monitoring clock |
| rst_ni | input | 1 | Active-low reset, synchronous to mon_clk_i (also clears the oscillator-domain marker) |
| osc_clk_i | input | 1 | Oscillator clock being watched |
| mon_en_i | input | 1 | 1 = monitoring active |
| self_clk_sel_i | input | 1 | Failure response: 1 = self-clock request, 0 = system reset request |
| fail_evt_o | output | 1 | One-cycle pulse when a loss is declared |
| self_clk_req_o | output | 1 | Sticky request to fall back to self-clocking |
| sys_rst_req_o | output | 1 | Sticky request for a system reset |

## Verification
A stuck or miscounted timeout counter shows at the ports in one of two ways:
- a failure pulse that arrives outside the R3 window after the oscillator stops, or
- a spurious pulse while a healthy oscillator runs. This becomes visible within about LIMIT cycles.

A broken synchroniser or edge detector has a different signature:
- it either never clears the count, so a healthy clock is declared lost within one timeout;
- or it keeps clearing it, so no pulse appears at all.

A wrong response latch shows one cycle after the pulse, as the wrong request or a request that drops before reset.

// File: rtl/clkmon_pkg.sv
// Shared types and defaults for the reference clock loss monitor.
package clkmon_pkg;

    // Response chosen on a failure; the value equals the select input level.
    typedef enum logic {
        RESP_SYS_RESET = 1'b0,
        RESP_SELF_CLK  = 1'b1
    } resp_e;

    localparam int unsigned DEF_LIMIT       = 256;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/clkmon_toggle.sv
// Oscillator-domain marker: flips on every rising oscillator edge.
// Assumes: rst_ni may arrive while the oscillator is stopped, so this one
// flop is cleared asynchronously; its level only matters through its changes.
module clkmon_toggle (
    input  logic osc_clk_i,
    input  logic rst_ni,
    output logic tog_o
);

    logic tog_q;

    // Flip the marker on each oscillator rising edge.
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/clkmon_sync.sv
// Multi-flop level synchroniser into the monitoring clock domain.
// Assumes: input is a slowly changing level (a toggle), STAGES >= 2.
module clkmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous level.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[0] <= 1'b0;
                    else         stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Let the captured level settle through one more flop.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) stage_q[i] <= 1'b0;
                    else         stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clkmon_timer.sv
// Detects marker changes and times the gap since the last one.
// Emits a one-cycle fail pulse when the gap reaches LIMIT cycles.
// Assumes: LIMIT >= 2, tog_sync_i already in this clock domain.
module clkmon_timer #(
    parameter int unsigned LIMIT = 256,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tog_sync_i,
    output logic fail_o
);

    logic          tog_prev_q;
    logic          edge_det;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          fail_q;
    logic          at_last;

    assign edge_det = tog_sync_i ^ tog_prev_q;
    assign at_last  = (cnt_q == CW'(LIMIT - 1));

    // Remember the previous synchronised marker for change detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) tog_prev_q <= 1'b0;
        else         tog_prev_q <= tog_sync_i;
    end

    // Next gap count: clear on life sign or disable, saturate at LIMIT.
    always_comb begin
        if (!en_i || edge_det) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_d = cnt_q + CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Register the gap count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // Pulse once as the count steps onto the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) fail_q <= 1'b0;
        else         fail_q <= en_i && !edge_det && at_last;
    end

    assign fail_o = fail_q;

    AST_FAIL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |=> !fail_o); // R4
    AST_NO_FAIL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !fail_o); // R8
    AST_EDGE_BLOCKS_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_det |=> !fail_o); // R2
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(LIMIT)); // R3

endmodule

// File: rtl/clkmon_resp.sv
// Turns a fail pulse into a sticky self-clock or system reset request.
// Assumes: the select level is valid in the cycle of the fail pulse.
module clkmon_resp
    import clkmon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fail_i,
    input  logic sel_i,
    output logic self_clk_req_o,
    output logic sys_rst_req_o
);

    resp_e resp;
    logic  sc_q;
    logic  rr_q;

    assign resp = resp_e'(sel_i);

    // Latch the self-clock request; only reset clears it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                               sc_q <= 1'b0;
        else if (fail_i && resp == RESP_SELF_CLK)  sc_q <= 1'b1;
    end

    // Latch the system reset request; only reset clears it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                               rr_q <= 1'b0;
        else if (fail_i && resp == RESP_SYS_RESET) rr_q <= 1'b1;
    end

    assign self_clk_req_o = sc_q;
    assign sys_rst_req_o  = rr_q;

    AST_SC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        self_clk_req_o |=> self_clk_req_o); // R7
    AST_RR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_req_o |=> sys_rst_req_o); // R7
    AST_SC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(self_clk_req_o) |-> $past(fail_i && sel_i)); // R5
    AST_RR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_req_o) |-> $past(fail_i && !sel_i)); // R6

endmodule

// File: rtl/clk_loss_mon.sv
// Reference clock loss monitor top: marker, synchroniser, gap timer and
// response latch. Assumes mon_clk_i never stops and rst_ni is synchronous
// to it.
module clk_loss_mon #(
    parameter int unsigned LIMIT       = clkmon_pkg::DEF_LIMIT,
    parameter int unsigned SYNC_STAGES = clkmon_pkg::DEF_SYNC_STAGES
) (
    input  logic mon_clk_i,
    input  logic rst_ni,
    input  logic osc_clk_i,
    input  logic mon_en_i,
    input  logic self_clk_sel_i,
    output logic fail_evt_o,
    output logic self_clk_req_o,
    output logic sys_rst_req_o
);

    logic tog_osc;
    logic tog_mon;
    logic fail;

    clkmon_toggle u_toggle (
        .osc_clk_i (osc_clk_i),
        .rst_ni    (rst_ni),
        .tog_o     (tog_osc)
    );

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (mon_clk_i),
        .rst_ni (rst_ni),
        .d_i    (tog_osc),
        .q_o    (tog_mon)
    );

    clkmon_timer #(.LIMIT(LIMIT)) u_timer (
        .clk_i      (mon_clk_i),
        .rst_ni     (rst_ni),
        .en_i       (mon_en_i),
        .tog_sync_i (tog_mon),
        .fail_o     (fail)
    );

    clkmon_resp u_resp (
        .clk_i          (mon_clk_i),
        .rst_ni         (rst_ni),
        .fail_i         (fail),
        .sel_i          (self_clk_sel_i),
        .self_clk_req_o (self_clk_req_o),
        .sys_rst_req_o  (sys_rst_req_o)
    );

    assign fail_evt_o = fail;

    AST_REQ_EXCLUSIVE_START: assert property (@(posedge mon_clk_i) disable iff (!rst_ni)
        !(fail_evt_o && $past(!mon_en_i))); // R8

endmodule

// File: tb/clk_loss_mon_tb.sv
`timescale 1ns/1ps
module clk_loss_mon_tb;

    localparam int LIMIT = 16;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b0;
    logic en = 1'b0;
    logic sel = 1'b0;
    logic fail_evt, sc_req, rr_req;

    bit  osc_run = 1'b1;
    real osc_half = 18.3;

    int cyc = 0;
    int last_edge = 0;
    int en_ref = 0;
    int vectors = 0;
    int miscompares = 0;
    bit exp_q[$];
    bit pending = 1'b0;
    bit pend_sel = 1'b0;

    clk_loss_mon #(.LIMIT(LIMIT), .SYNC_STAGES(SYNC)) u_dut (
        .mon_clk_i      (clk),
        .rst_ni         (rst_n),
        .osc_clk_i      (osc),
        .mon_en_i       (en),
        .self_clk_sel_i (sel),
        .fail_evt_o     (fail_evt),
        .self_clk_req_o (sc_req),
        .sys_rst_req_o  (rr_req)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            if (osc_run) begin
                #(osc_half) osc = ~osc;
            end else begin
                #1;
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge osc) last_edge = cyc;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_fail(input bit s);
        exp_q.push_back(s);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        pending = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        en_ref = cyc;
    endtask

    // Scoreboard monitor: pop expected failures, check timing and response.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pending) begin
                pending = 1'b0;
                chk(!fail_evt, "R4 pulse width", fail_evt, 0);
                if (pend_sel) begin
                    chk(sc_req && !rr_req, "R5 self-clock request", {sc_req, rr_req}, 2);
                end else begin
                    chk(rr_req && !sc_req, "R6 reset request", {sc_req, rr_req}, 1);
                end
            end
            if (fail_evt) begin
                int refc;
                int d;
                refc = (last_edge > en_ref) ? last_edge : en_ref;
                d = cyc - refc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 R8 unexpected failure event", 1, 0);
                end else begin
                    pend_sel = exp_q.pop_front();
                    pending = 1'b1;
                    chk(d >= LIMIT && d <= LIMIT + SYNC + 2, "R3 timeout delay", d, LIMIT + SYNC + 1);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk({fail_evt, sc_req, rr_req} == 3'b000, "R1 outputs in reset", {fail_evt, sc_req, rr_req}, 0);
        do_reset();
        chk({fail_evt, sc_req, rr_req} == 3'b000, "R1 outputs after reset", {fail_evt, sc_req, rr_req}, 0);

        // Healthy oscillator, monitoring on.
        en = 1'b1; en_ref = cyc; sel = 1'b1;
        wait_cyc(400);
        chk({sc_req, rr_req} == 2'b00, "R2 no request with running clock", {sc_req, rr_req}, 0);

        // Stop the oscillator, self-clock response.
        osc_run = 1'b0;
        expect_fail(1'b1);
        wait_cyc(60);
        chk(exp_q.size() == 0, "R3 failure reported", exp_q.size(), 0);
        chk(sc_req == 1'b1, "R5 self-clock request level", sc_req, 1);
        wait_cyc(100);
        osc_run = 1'b1;
        wait_cyc(200);
        chk(sc_req == 1'b1 && rr_req == 1'b0, "R7 request sticky after clock returns", {sc_req, rr_req}, 2);

        // Reset clears; then reset response.
        do_reset();
        chk({fail_evt, sc_req, rr_req} == 3'b000, "R1 R7 reset clears request", {fail_evt, sc_req, rr_req}, 0);
        sel = 1'b0;
        wait_cyc(50);
        osc_run = 1'b0;
        expect_fail(1'b0);
        wait_cyc(60);
        chk(exp_q.size() == 0, "R3 failure reported", exp_q.size(), 0);
        chk(rr_req == 1'b1 && sc_req == 1'b0, "R6 reset request level", {sc_req, rr_req}, 1);

        // Disabled monitoring with stopped oscillator.
        en = 1'b0;
        do_reset();
        wait_cyc(200);
        chk({sc_req, rr_req} == 2'b00, "R8 no request when disabled", {sc_req, rr_req}, 0);

        // Partial enable, drop, re-enable: full timeout needed.
        sel = 1'b1;
        en = 1'b1;
        wait_cyc(8);
        en = 1'b0;
        wait_cyc(2);
        en = 1'b1; en_ref = cyc;
        expect_fail(1'b1);
        wait_cyc(60);
        chk(exp_q.size() == 0, "R9 failure after re-enable", exp_q.size(), 0);
        chk(sc_req == 1'b1, "R9 self-clock request after re-enable", sc_req, 1);

        // Slow oscillator is reported as lost.
        sel = 1'b0;
        osc_half = 75.0;
        osc_run = 1'b1;
        do_reset();
        expect_fail(1'b0);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) wait_cyc(1);
        chk(exp_q.size() == 0, "R10 slow clock detected", exp_q.size(), 0);
        wait_cyc(1);
        chk(rr_req == 1'b1, "R10 reset request for slow clock", rr_req, 1);
        do_reset();
        wait_cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule